// File: doc/BRIEF.md
# Two-Stage Serial Clock Slot Divider

This block turns the peripheral clock into the bit-phase timing for an I2C master's byte engine. Every serial clock period is split into 22 equal slots, and the block issues a one-cycle `slot_tick_o` at the start of each slot. A slot lasts (A+1) x (B+1) peripheral clocks, so the serial clock runs at Fclk / (22 x (A+1) x (B+1)). It can never run faster than Fclk / 22.

The two divider fields come from a 16-bit control word. The coarse field A is 2 bits wide at bits [15:14] and gives a factor of 1 to 4. The fine field B is 6 bits wide at bits [13:8] and gives a factor of 1 to 64. The three divider stages are chained:

- Stage A fires once every A+1 clocks.
- Stage B counts those firings and issues a slot tick on every (B+1)-th one.
- A slot counter numbers the slots 0 to 21.

The engine reads `slot_idx_o` to know which phase of the serial clock it is in. `period_end_o` marks the last slot of each period. Software chooses the field values. The block only counts.

A two-state machine controls the counters. In state IDLE the counters are held at zero and no tick is issued. The transition IDLE to RUN (named START) happens on the first clock edge with `run_i` high, and that edge also captures both fields. The machine stays in RUN (named HOLD) while `run_i` stays high. The transition RUN to IDLE (named STOP) happens on the first edge with `run_i` low. While in IDLE with `run_i` low, the machine stays in IDLE (named REST).

Top module: `scl_slot_div`

## Requirements
- R1: After reset, `slot_tick_o` and `period_end_o` are 0 and `slot_idx_o` is 0.
- R2: Fields A (control bits [15:14]) and B (control bits [13:8]) are captured only on the START edge. Any change to the control word while in RUN has no effect on tick timing until the next START.
- R3: Counting the first cycle after the START edge as cycle 1, the k-th slot tick appears in cycle k x (A+1) x (B+1).
- R4: With A=0 and B=0, `slot_tick_o` is high on every cycle after START while `run_i` stays high.
- R5: When `run_i` is low, `slot_tick_o` and `period_end_o` are 0 in that same cycle and all counters return to zero. A later START again waits a full (A+1) x (B+1) cycles for its first tick.
- R6: `slot_idx_o` reads 0 during the first tick after START and advances by one on each tick, wrapping from 21 back to 0.
- R7: `period_end_o` is high exactly in the cycles where a tick falls on slot 21. This gives one period end per 22 x (A+1) x (B+1) cycles.
- R8: Control bits [7:0] have no effect on tick timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | High while the engine needs slot timing |
| ctl_word | input | 16 | Control word carrying fields A and B |
| slot_tick_o | output | 1 | One-cycle pulse at the start of each slot |
| slot_idx_o | output | 5 | Index of the current slot, 0 to 21 |
| period_end_o | output | 1 | Tick that falls on slot 21 |

## Verification
The divider is run with several field pairs:

- A=B=0 shows that the degenerate every-cycle case needs no special path.
- A pair with only A non-zero and a pair with only B non-zero separate the two stages, so a swapped or misplaced field shows up as a wrong tick spacing.
- A mixed pair and a near-maximum pair check that the two factors multiply and that the 6-bit counter wraps at its top value.

In each case the control word also carries junk in bits [7:0]. A run that rewrites the control word mid-transfer shows whether the fields are captured or followed live. Stop and restart sequences check that every counter clears, since a partly counted slot would make the first interval after restart too short.

// File: rtl/scl_slot_div_pkg.sv
package scl_slot_div_pkg;
    localparam int CTL_W_DEF      = 16;
    localparam int DIVA_LSB_DEF   = 14;
    localparam int DIVA_W_DEF     = 2;
    localparam int DIVB_LSB_DEF   = 8;
    localparam int DIVB_W_DEF     = 6;
    localparam int SLOTS_DEF      = 22;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/div_stage.sv
module div_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    // Fires on the step that finds the counter at its limit
    assign hit   = step && (cnt_q == limit);
    assign count = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step) begin
            if (cnt_q == limit) cnt_q <= '0;
            else                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/scl_slot_div.sv
module scl_slot_div
    import scl_slot_div_pkg::*;
#(
    parameter int CTL_W    = CTL_W_DEF,
    parameter int DIVA_LSB = DIVA_LSB_DEF,
    parameter int DIVA_W   = DIVA_W_DEF,
    parameter int DIVB_LSB = DIVB_LSB_DEF,
    parameter int DIVB_W   = DIVB_W_DEF,
    parameter int SLOTS    = SLOTS_DEF,
    localparam int SLOT_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [CTL_W-1:0]  ctl_word,
    output logic              slot_tick_o,
    output logic [SLOT_W-1:0] slot_idx_o,
    output logic              period_end_o
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
    localparam logic [CTL_W-1:0]  FIELD_MASK =
        CTL_W'(((1 << DIVA_W) - 1) << DIVA_LSB) |
        CTL_W'(((1 << DIVB_W) - 1) << DIVB_LSB);

    div_state_e         state_q, state_d;
    logic [DIVA_W-1:0]  lat_a_q;
    logic [DIVB_W-1:0]  lat_b_q;
    logic               active;
    logic               a_en, b_hit, slot_wrap;
    logic [DIVA_W-1:0]  a_cnt;
    logic [DIVB_W-1:0]  b_cnt;
    logic [SLOT_W-1:0]  slot_cnt;
    logic               ctl_unused;

    // Bits outside both fields are reduced and dropped
    assign ctl_unused = ^(ctl_word & ~FIELD_MASK);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: START, HOLD, STOP, REST
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_i)  state_d = ST_RUN;
            ST_RUN:  if (!run_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Field capture on the START edge only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_a_q <= '0;
            lat_b_q <= '0;
        end else if (state_q == ST_IDLE && run_i) begin
            lat_a_q <= ctl_word[DIVA_LSB +: DIVA_W];
            lat_b_q <= ctl_word[DIVB_LSB +: DIVB_W];
        end
    end

    assign active = (state_q == ST_RUN) && run_i;

    div_stage #(.W(DIVA_W)) u_stage_a (
        .clk(clk), .rst_n(rst_n), .clr(!active), .step(active),
        .limit(lat_a_q), .count(a_cnt), .hit(a_en)
    );

    div_stage #(.W(DIVB_W)) u_stage_b (
        .clk(clk), .rst_n(rst_n), .clr(!active), .step(a_en),
        .limit(lat_b_q), .count(b_cnt), .hit(b_hit)
    );

    div_stage #(.W(SLOT_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .clr(!active), .step(b_hit),
        .limit(SLOT_LAST), .count(slot_cnt), .hit(slot_wrap)
    );

    // Outputs
    always_comb begin
        slot_tick_o  = 1'b0;
        period_end_o = 1'b0;
        slot_idx_o   = slot_cnt;
        unique case (state_q)
            ST_IDLE: begin
                slot_tick_o  = 1'b0;
                period_end_o = 1'b0;
            end
            ST_RUN: begin
                slot_tick_o  = b_hit;
                period_end_o = slot_wrap;
            end
            default: ;
        endcase
    end

    // R2: captured fields never move while running
    a_r2_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && run_i) |=> ($stable(lat_a_q) && $stable(lat_b_q)));

    // R3: a slot tick requires the coarse stage to fire in the same cycle
    a_r3_tick_needs_a: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick_o |-> a_en);

    // R3: fine stage counter stays within the captured limit
    a_r3_b_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        b_cnt <= lat_b_q);

    // R5: a cycle without run leaves every counter at zero
    a_r5_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (slot_idx_o == '0 && a_cnt == '0 && b_cnt == '0));

    // R6: slot index never passes the last slot
    a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idx_o <= SLOT_LAST);

    // R7: period end is always a tick
    a_r7_end_is_tick: assert property (@(posedge clk) disable iff (!rst_n)
        period_end_o |-> slot_tick_o);

    // R7: after a period end that keeps running, slot 0 follows
    a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        period_end_o |=> (slot_idx_o == '0));
endmodule

// File: tb/scl_slot_div_tb_top.sv
module scl_slot_div_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic [15:0] ctl_word = 16'h0;
    logic        slot_tick_o;
    logic [4:0]  slot_idx_o;
    logic        period_end_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    scl_slot_div dut_i (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .ctl_word(ctl_word),
        .slot_tick_o(slot_tick_o), .slot_idx_o(slot_idx_o),
        .period_end_o(period_end_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs 44 slots with fields a/b; optionally rewrites the word in cycle 1
    task automatic run_case(input int a, input int b, input logic [7:0] junk,
                            input bit change, input string tag);
        int per;
        int cyc;
        int ticks;
        per = (a + 1) * (b + 1);
        @(negedge clk);
        ctl_word = {a[1:0], b[5:0], junk};
        run_i = 1'b1;
        @(posedge clk);
        cyc = 0;
        ticks = 0;
        while (ticks < 44) begin
            @(negedge clk);
            cyc++;
            if (change && cyc == 1) ctl_word = {2'd3, 6'd7, ~junk};
            if (slot_tick_o) begin
                chk(cyc == per * (ticks + 1), {tag, " R3 tick cycle"}, cyc, per * (ticks + 1));
                chk(slot_idx_o == 5'(ticks % 22), {tag, " R6 slot index"}, slot_idx_o, ticks % 22);
                chk(period_end_o == ((ticks % 22) == 21), {tag, " R7 period end"},
                    period_end_o, (ticks % 22) == 21);
                ticks++;
            end else begin
                chk(period_end_o == 1'b0, {tag, " R7 end without tick"}, period_end_o, 0);
                if (cyc > per * (ticks + 1)) begin
                    chk(1'b0, {tag, " R3 tick missing"}, cyc, per * (ticks + 1));
                    ticks = 44;
                end
            end
        end
        // R5: dropping run silences the tick in the same cycle
        run_i = 1'b0;
        #1;
        chk(slot_tick_o == 1'b0 && period_end_o == 1'b0, {tag, " R5 stop same cycle"},
            slot_tick_o, 0);
        @(negedge clk);
        chk(slot_idx_o == 5'd0, {tag, " R5 index cleared"}, slot_idx_o, 0);
    endtask

    task automatic t_reset;
        #1;
        chk(slot_tick_o == 1'b0, "R1 tick in reset", slot_tick_o, 0);
        chk(slot_idx_o == 5'd0, "R1 index in reset", slot_idx_o, 0);
        chk(period_end_o == 1'b0, "R1 end in reset", period_end_o, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(slot_tick_o == 1'b0 && slot_idx_o == 5'd0, "R1 after release", slot_idx_o, 0);
    endtask

    task automatic t_idle_quiet;
        int seen;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i == 20) ctl_word = 16'hFFFF;
            if (slot_tick_o) seen++;
        end
        chk(seen == 0, "R5 no ticks while idle", seen, 0);
    endtask

    task automatic t_restart;
        // Stop mid-slot, then restart: first tick must wait a full slot again
        int cyc;
        @(negedge clk);
        ctl_word = {2'd2, 6'd3, 8'h00};
        run_i = 1'b1;
        repeat (7) @(negedge clk);
        run_i = 1'b0;
        @(negedge clk);
        run_i = 1'b1;
        @(posedge clk);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!slot_tick_o && cyc < 100);
        chk(cyc == 12, "R5 restart first tick", cyc, 12);
        chk(slot_idx_o == 5'd0, "R6 restart index", slot_idx_o, 0);
        run_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        run_case(0, 0, 8'h5A, 1'b0, "R4 A0B0");
        run_case(1, 0, 8'hFF, 1'b0, "R8 A1B0");
        run_case(0, 5, 8'h81, 1'b0, "R8 A0B5");
        run_case(3, 2, 8'h3C, 1'b0, "A3B2");
        run_case(2, 63, 8'h00, 1'b0, "A2B63");
        run_case(1, 2, 8'hA5, 1'b1, "R2 midrun change");
        t_idle_quiet();
        run_case(0, 1, 8'h00, 1'b0, "R2 new fields after idle");
        t_restart();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule